// File: doc/BRIEF.md
# Shared Two-Thread Issue Queue with Per-Thread Occupancy Cap

This block holds operations that wait for one class of execution unit. Two threads offer it operations. Each operation carries a thread bit, two source tags, a ready flag for each source, and a destination tag. Result tags broadcast on the wakeup port set the ready flag of every matching source. Each cycle the block sends out the oldest waiting operation whose two sources are ready, as long as the execution unit is available. Thread identity plays no part in that choice.

Entries are kept in insertion order with the oldest in slot 0. An issue closes the gap by shifting younger entries down, and a new entry lands just above the survivors. At most one operation enters per cycle. When both threads are eligible, the entry slot alternates between them. Each thread may hold no more than half the queue depth, rounded up. A thread at its cap, or any thread while the queue is full, sees its stall line raised and its offer refused. The other thread's offer still goes in.

Top module: `iq_sched`

## Requirements
- R1: During and right after reset the queue is empty: issue_valid is 0, in_accept is 00 and in_stall is 00.
- R2: At most one in_accept bit is set in a cycle. An accepted operation occupies an entry from the next cycle and can issue in that cycle at the earliest.
- R3: An entry issues only when both of its source ready flags are set and unit_ready is 1. While unit_ready is 0 nothing issues and no entry is lost.
- R4: A wakeup (wake_valid with wake_tag) sets the ready flag of every stored source, first or second, whose tag equals wake_tag. The entry can issue from the cycle after the wakeup.
- R5: A wakeup in the same cycle as an insert also sets the matching source ready flags of the operation being inserted.
- R6: Among ready entries, the one inserted earliest issues, whichever thread owns it. issue_thread (0 or 1) and issue_dst_tag identify it.
- R7: The per-thread cap is ceil(DEPTH/2), which is 4 at the default depth of 8. in_stall[t] is 1 when thread t holds that many entries or the queue is full. An offer from a stalled thread is not accepted, while the other thread's offer in the same cycle is accepted.
- R8: When both threads are eligible to insert, the grant goes to the thread that was not granted last. After reset, thread 0 counts as first.
- R9: An issued entry frees its place. The owning thread's count drops in the following cycle, which clears in_stall for that thread if it was at its cap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 2 | Per-thread insert offer (bit t for thread t) |
| in_s0_tag | input | 2 x TAG_W | Per-thread first source tag |
| in_s0_rdy | input | 2 | Per-thread first source already ready |
| in_s1_tag | input | 2 x TAG_W | Per-thread second source tag |
| in_s1_rdy | input | 2 | Per-thread second source already ready |
| in_dst_tag | input | 2 x TAG_W | Per-thread destination tag |
| in_accept | output | 2 | Offer of thread t taken this cycle |
| in_stall | output | 2 | Thread t at its cap or queue full |
| wake_valid | input | 1 | Result tag broadcast valid |
| wake_tag | input | TAG_W | Broadcast result tag |
| unit_ready | input | 1 | Execution unit can take an operation |
| issue_valid | output | 1 | An operation issues this cycle |
| issue_thread | output | 1 | Thread of the issuing operation |
| issue_dst_tag | output | TAG_W | Destination tag of the issuing operation |

## Verification
The hardest state to reach is a queue where one thread sits at its cap while the other keeps offering, then frees an entry. That is the only way the refused offer, the accepted neighbour offer and the one-cycle lag of the stall release show up together. The stimulus first holds unit_ready low and fills thread 0 with operations that share one unready tag. It then offers from both threads, and finally broadcasts that tag and raises unit_ready, so that issue order, stall release and the thread-1 entry behind them can all be observed at the ports.

// File: rtl/iq_sched_pkg.sv
package iq_sched_pkg;
  localparam int NUM_THR = 2;

  // Per-thread entry ceiling from the queue depth
  function automatic int half_up(input int n);
    return (n + 1) / 2;
  endfunction
endpackage

// File: rtl/iq_ins_arb.sv
module iq_ins_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic [1:0] blocked,
  output logic [1:0] grant
);
  logic [1:0] elig;
  logic       last_q, last_d;

  assign elig = req & ~blocked;

  always_comb begin
    if (&elig) grant = last_q ? 2'b01 : 2'b10;
    else       grant = elig;
  end

  always_comb begin
    last_d = last_q;
    if (|grant) last_d = grant[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_q <= 1'b1;
    else if (|grant) last_q <= last_d;
  end

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R8
  alt_after_t0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&elig && grant[0]) |=> (!(&elig) || grant[1]));
  // R8
  alt_after_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&elig && grant[1]) |=> (!(&elig) || grant[0]));
endmodule

// File: rtl/iq_occ.sv
module iq_occ #(
  parameter int DEPTH = 8,
  parameter int CAP   = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic             ins_thr,
  input  logic             iss_en,
  input  logic             iss_thr,
  output logic [1:0]       at_cap,
  output logic             full,
  output logic [CNT_W-1:0] total
);
  logic [CNT_W-1:0] cnt_q [iq_sched_pkg::NUM_THR];
  logic [CNT_W-1:0] cnt_d [iq_sched_pkg::NUM_THR];

  for (genvar t = 0; t < iq_sched_pkg::NUM_THR; t++) begin : g_thr
    logic up, dn;
    assign up = ins_en && (ins_thr == t[0]);
    assign dn = iss_en && (iss_thr == t[0]);

    always_comb begin
      cnt_d[t] = cnt_q[t];
      if (up && !dn)      cnt_d[t] = cnt_q[t] + 1'b1;
      else if (dn && !up) cnt_d[t] = cnt_q[t] - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q[t] <= '0;
      else if (up || dn) cnt_q[t] <= cnt_d[t];
    end

    assign at_cap[t] = (cnt_q[t] >= CNT_W'(CAP));

    // R7
    cap_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[t] <= CNT_W'(CAP));
  end

  assign total = cnt_q[0] + cnt_q[1];
  assign full  = (total >= CNT_W'(DEPTH));

  // R7
  depth_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    total <= CNT_W'(DEPTH));
endmodule

// File: rtl/iq_pick.sv
module iq_pick #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic [DEPTH-1:0] rdy,
  output logic             found,
  output logic [IDX_W-1:0] sel
);
  // Slot 0 holds the oldest entry, so the lowest ready index wins
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (rdy[i]) begin
        found = 1'b1;
        sel   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/iq_sched.sv
module iq_sched #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            in_valid,
  input  logic [1:0][TAG_W-1:0] in_s0_tag,
  input  logic [1:0]            in_s0_rdy,
  input  logic [1:0][TAG_W-1:0] in_s1_tag,
  input  logic [1:0]            in_s1_rdy,
  input  logic [1:0][TAG_W-1:0] in_dst_tag,
  output logic [1:0]            in_accept,
  output logic [1:0]            in_stall,
  input  logic                  wake_valid,
  input  logic [TAG_W-1:0]      wake_tag,
  input  logic                  unit_ready,
  output logic                  issue_valid,
  output logic                  issue_thread,
  output logic [TAG_W-1:0]      issue_dst_tag
);
  localparam int CAP   = iq_sched_pkg::half_up(DEPTH);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 2);

  // Entry state, slot 0 oldest, valid entries packed at the bottom
  logic [DEPTH-1:0] e_vld, e_thr, e_r0, e_r1;
  logic [TAG_W-1:0] e_s0 [DEPTH];
  logic [TAG_W-1:0] e_s1 [DEPTH];
  logic [TAG_W-1:0] e_dst[DEPTH];

  logic [DEPTH-1:0] n_vld, n_thr, n_r0, n_r1;
  logic [TAG_W-1:0] n_s0 [DEPTH];
  logic [TAG_W-1:0] n_s1 [DEPTH];
  logic [TAG_W-1:0] n_dst[DEPTH];

  // Contents of the slot above each slot, for gap closing
  logic [DEPTH-1:0] up_vld, up_thr, up_r0, up_r1;
  logic [TAG_W-1:0] up_s0 [DEPTH];
  logic [TAG_W-1:0] up_s1 [DEPTH];
  logic [TAG_W-1:0] up_dst[DEPTH];

  logic [1:0]       at_cap;
  logic             full;
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] wr_pos;
  logic             ins_fire, ins_sel, issue_fire, pick_found;
  logic [IDX_W-1:0] pick_sel;
  logic [DEPTH-1:0] rdy_vec;
  logic             upd_en;

  logic [TAG_W-1:0] ins_s0, ins_s1, ins_dst;
  logic             ins_r0, ins_r1;

  // Insert side
  assign in_stall = at_cap | {2{full}};

  iq_ins_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (in_valid),
    .blocked (in_stall),
    .grant   (in_accept)
  );

  assign ins_fire = |in_accept;
  assign ins_sel  = in_accept[1];
  assign ins_s0   = in_s0_tag[ins_sel];
  assign ins_s1   = in_s1_tag[ins_sel];
  assign ins_dst  = in_dst_tag[ins_sel];
  assign ins_r0   = in_s0_rdy[ins_sel];
  assign ins_r1   = in_s1_rdy[ins_sel];

  // Select side
  assign rdy_vec = e_vld & e_r0 & e_r1;

  iq_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
    .rdy   (rdy_vec),
    .found (pick_found),
    .sel   (pick_sel)
  );

  assign issue_fire    = pick_found && unit_ready;
  assign issue_valid   = issue_fire;
  assign issue_thread  = e_thr[pick_sel];
  assign issue_dst_tag = e_dst[pick_sel];

  iq_occ #(.DEPTH(DEPTH), .CAP(CAP), .CNT_W(CNT_W)) u_occ (
    .clk     (clk),
    .rst_n   (rst_n),
    .ins_en  (ins_fire),
    .ins_thr (ins_sel),
    .iss_en  (issue_fire),
    .iss_thr (issue_thread),
    .at_cap  (at_cap),
    .full    (full),
    .total   (total)
  );

  assign wr_pos = total - CNT_W'(issue_fire);

  for (genvar g = 0; g < DEPTH; g++) begin : g_up
    if (g < DEPTH - 1) begin : g_mid
      assign up_vld[g] = e_vld[g+1];
      assign up_thr[g] = e_thr[g+1];
      assign up_r0[g]  = e_r0[g+1];
      assign up_r1[g]  = e_r1[g+1];
      assign up_s0[g]  = e_s0[g+1];
      assign up_s1[g]  = e_s1[g+1];
      assign up_dst[g] = e_dst[g+1];
    end else begin : g_top
      assign up_vld[g] = 1'b0;
      assign up_thr[g] = 1'b0;
      assign up_r0[g]  = 1'b0;
      assign up_r1[g]  = 1'b0;
      assign up_s0[g]  = '0;
      assign up_s1[g]  = '0;
      assign up_dst[g] = '0;
    end
  end

  // Next state: close the gap, apply wakeup, then place the insert
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic shift;
      shift = issue_fire && (IDX_W'(i) >= pick_sel);
      n_vld[i] = shift ? up_vld[i] : e_vld[i];
      n_thr[i] = shift ? up_thr[i] : e_thr[i];
      n_s0[i]  = shift ? up_s0[i]  : e_s0[i];
      n_s1[i]  = shift ? up_s1[i]  : e_s1[i];
      n_dst[i] = shift ? up_dst[i] : e_dst[i];
      n_r0[i]  = (shift ? up_r0[i] : e_r0[i]) ||
                 (wake_valid && (n_s0[i] == wake_tag));
      n_r1[i]  = (shift ? up_r1[i] : e_r1[i]) ||
                 (wake_valid && (n_s1[i] == wake_tag));
      if (ins_fire && (CNT_W'(i) == wr_pos)) begin
        n_vld[i] = 1'b1;
        n_thr[i] = ins_sel;
        n_s0[i]  = ins_s0;
        n_s1[i]  = ins_s1;
        n_dst[i] = ins_dst;
        n_r0[i]  = ins_r0 || (wake_valid && (ins_s0 == wake_tag));
        n_r1[i]  = ins_r1 || (wake_valid && (ins_s1 == wake_tag));
      end
    end
  end

  assign upd_en = issue_fire || ins_fire || wake_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      e_vld <= '0;
    else if (upd_en) e_vld <= n_vld;
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      e_thr <= n_thr;
      e_r0  <= n_r0;
      e_r1  <= n_r1;
      for (int i = 0; i < DEPTH; i++) begin
        e_s0[i]  <= n_s0[i];
        e_s1[i]  <= n_s1[i];
        e_dst[i] <= n_dst[i];
      end
    end
  end

  // R3
  issue_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> unit_ready);
  // R7
  accept_vs_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_accept & in_stall) == 2'b00);
  // R9
  occ_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(e_vld) == int'(total));
  // R2
  packed_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((e_vld + 1'b1) & e_vld) == '0);
endmodule

// File: tb/iq_sched_test.sv
module iq_sched_test;
  localparam int TW = 6;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [1:0]          in_valid;
  logic [1:0][TW-1:0]  in_s0_tag, in_s1_tag, in_dst_tag;
  logic [1:0]          in_s0_rdy, in_s1_rdy;
  logic [1:0]          in_accept, in_stall;
  logic                wake_valid;
  logic [TW-1:0]       wake_tag;
  logic                unit_ready;
  logic                issue_valid, issue_thread;
  logic [TW-1:0]       issue_dst_tag;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #2.5 clk = ~clk;

  iq_sched #(.DEPTH(8), .TAG_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_s0_tag(in_s0_tag), .in_s0_rdy(in_s0_rdy),
    .in_s1_tag(in_s1_tag), .in_s1_rdy(in_s1_rdy),
    .in_dst_tag(in_dst_tag), .in_accept(in_accept), .in_stall(in_stall),
    .wake_valid(wake_valid), .wake_tag(wake_tag), .unit_ready(unit_ready),
    .issue_valid(issue_valid), .issue_thread(issue_thread),
    .issue_dst_tag(issue_dst_tag)
  );

  typedef struct packed {
    logic [1:0]    iv;
    logic [TW-1:0] as0; logic ar0; logic [TW-1:0] as1; logic ar1; logic [TW-1:0] ad;
    logic [TW-1:0] bs0; logic br0; logic [TW-1:0] bs1; logic br1; logic [TW-1:0] bd;
    logic          wv;  logic [TW-1:0] wt;
    logic          ur;
    logic [1:0]    acc; logic [1:0] stl;
    logic          isv; logic ist; logic [TW-1:0] isd;
  } vec_t;

  // iv, A op(s0,r0,s1,r1,dst), B op, wake, unit_ready, expected accept, stall, issue
  localparam vec_t TBL [13] = '{
    '{0, 0,1,0,1,0,   0,1,0,1,0,   0,0,  1, 0,0, 0,0,0},  // idle
    '{1, 10,0,11,1,20, 0,1,0,1,0,  0,0,  1, 1,0, 0,0,0},  // R2 t0 insert, s0 waiting
    '{2, 0,1,0,1,0,   0,1,0,1,21,  0,0,  1, 2,0, 0,0,0},  // R2 t1 insert ready
    '{0, 0,1,0,1,0,   0,1,0,1,0,   0,0,  1, 0,0, 1,1,21}, // R6 younger ready one goes
    '{0, 0,1,0,1,0,   0,1,0,1,0,   1,10, 1, 0,0, 0,0,0},  // R4 wake, not yet eligible
    '{0, 0,1,0,1,0,   0,1,0,1,0,   0,0,  0, 0,0, 0,0,0},  // R3 unit busy
    '{0, 0,1,0,1,0,   0,1,0,1,0,   0,0,  1, 0,0, 1,0,20}, // R4 woken entry issues
    '{3, 30,0,0,1,22, 0,1,32,0,23, 1,30, 1, 1,0, 0,0,0},  // R8 t0 first, R5 same-cycle wake
    '{3, 0,1,0,1,24,  0,1,32,0,23, 0,0,  1, 2,0, 1,0,22}, // R8 t1 next, R5 entry issues
    '{1, 0,1,0,1,24,  0,1,0,1,0,   1,32, 1, 1,0, 0,0,0},  // R4 wake second source
    '{0, 0,1,0,1,0,   0,1,0,1,0,   0,0,  1, 0,0, 1,1,23}, // R6 oldest despite two ready
    '{0, 0,1,0,1,0,   0,1,0,1,0,   0,0,  1, 0,0, 1,0,24}, // R6
    '{0, 0,1,0,1,0,   0,1,0,1,0,   0,0,  1, 0,0, 0,0,0}   // drained
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input string req);
    @(negedge clk);
    in_valid      = v.iv;
    in_s0_tag[0]  = v.as0; in_s0_rdy[0] = v.ar0;
    in_s1_tag[0]  = v.as1; in_s1_rdy[0] = v.ar1; in_dst_tag[0] = v.ad;
    in_s0_tag[1]  = v.bs0; in_s0_rdy[1] = v.br0;
    in_s1_tag[1]  = v.bs1; in_s1_rdy[1] = v.br1; in_dst_tag[1] = v.bd;
    wake_valid    = v.wv;  wake_tag = v.wt;
    unit_ready    = v.ur;
    #1;
    chk(req, "accept", 32'(in_accept), 32'(v.acc));
    chk(req, "stall", 32'(in_stall), 32'(v.stl));
    chk(req, "issue_valid", 32'(issue_valid), 32'(v.isv));
    if (v.isv) begin
      chk(req, "issue_thread", 32'(issue_thread), 32'(v.ist));
      chk(req, "issue_dst", 32'(issue_dst_tag), 32'(v.isd));
    end
  endtask

  // Compact builder: second sources always ready
  function automatic vec_t mk(input logic [1:0] iv,
      input logic [TW-1:0] as0, input logic ar0, input logic [TW-1:0] ad,
      input logic [TW-1:0] bs0, input logic br0, input logic [TW-1:0] bd,
      input logic wv, input logic [TW-1:0] wt, input logic ur,
      input logic [1:0] acc, input logic [1:0] stl,
      input logic isv, input logic ist, input logic [TW-1:0] isd);
    vec_t v;
    v = '{iv, as0, ar0, 6'd0, 1'b1, ad, bs0, br0, 6'd0, 1'b1, bd,
          wv, wt, ur, acc, stl, isv, ist, isd};
    return v;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = '0; in_s0_tag = '0; in_s1_tag = '0; in_dst_tag = '0;
    in_s0_rdy = '0; in_s1_rdy = '0;
    wake_valid = 1'b0; wake_tag = '0; unit_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "issue_valid in reset", 32'(issue_valid), 0);
    chk("R1", "stall in reset", 32'(in_stall), 0);
    @(negedge clk);
    rst_n = 1'b1;

    foreach (TBL[k]) run_vec(TBL[k], "TBL");

    // R7 fill thread 0 to its cap of 4 with unit busy
    for (int k = 0; k < 4; k++)
      run_vec(mk(1, 40,0,6'(50+k), 0,1,0, 0,0, 0, 1,0, 0,0,0), "R7 fill");
    run_vec(mk(1, 40,0,54, 0,1,0,  0,0, 0, 0,1, 0,0,0), "R7 refused at cap");
    run_vec(mk(3, 40,0,54, 0,1,60, 0,0, 0, 2,1, 0,0,0), "R7 other thread proceeds");
    run_vec(mk(0, 0,1,0,   0,1,0,  1,40, 0, 0,1, 0,0,0), "R4 wake under busy unit");
    run_vec(mk(0, 0,1,0,   0,1,0,  0,0, 1, 0,1, 1,0,50), "R9 stall holds while issuing");
    run_vec(mk(0, 0,1,0,   0,1,0,  0,0, 1, 0,0, 1,0,51), "R9 stall released");
    run_vec(mk(0, 0,1,0,   0,1,0,  0,0, 1, 0,0, 1,0,52), "R6 drain");
    run_vec(mk(0, 0,1,0,   0,1,0,  0,0, 1, 0,0, 1,0,53), "R6 drain");
    run_vec(mk(0, 0,1,0,   0,1,0,  0,0, 1, 0,0, 1,1,60), "R6 drain");
    run_vec(mk(0, 0,1,0,   0,1,0,  0,0, 1, 0,0, 0,0,0),  "R3 empty");

    // R8 alternation: last grant went to thread 1
    for (int k = 0; k < 4; k++)
      run_vec(mk(3, 0,1,70, 0,1,71, 0,0, 0, (k % 2 == 0) ? 2'b01 : 2'b10, 0, 0,0,0),
              "R8 alternate");
    for (int k = 0; k < 4; k++)
      run_vec(mk(0, 0,1,0, 0,1,0, 0,0, 1, 0,0, 1, k[0], (k % 2 == 0) ? 6'd70 : 6'd71),
              "R6 thread-blind order");

    // R1 reset with a pending entry, then R8 reset priority
    run_vec(mk(1, 0,1,80, 0,1,0, 0,0, 0, 1,0, 0,0,0), "R2 load before reset");
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = '0;
    unit_ready = 1'b1;
    #1;
    chk("R1", "issue_valid after reset", 32'(issue_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_vec(mk(0, 0,1,0,  0,1,0,  0,0, 1, 0,0, 0,0,0), "R1 queue empty");
    run_vec(mk(3, 0,1,81, 0,1,82, 0,0, 1, 1,0, 0,0,0), "R8 thread 0 first after reset");
    run_vec(mk(0, 0,1,0,  0,1,0,  0,0, 1, 0,0, 1,0,81), "R2 next-cycle issue");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule